// File: doc/BRIEF.md
# Binary Field Inverter, Almost Inverse Method

This block computes the multiplicative inverse of a nonzero element of GF(2^89), represented in the polynomial basis defined by the trinomial x^89 + x^38 + 1. A caller places the element on `operand` and pulses `start` while the block is idle. Some cycles later `done` pulses for one cycle, and `result` then holds the inverse. A zero operand has no inverse. In that case `err` is set and `done` follows at once, with no iteration.

The core is the almost inverse iteration on four working polynomials `F`, `G`, `B` and `C`, plus a shift count `k`. The iteration ends with `B * a = x^k mod p`, and a fix-up pass then divides by `x^k`. Three parts are accelerated:
- Low-order zeros of `F` are stripped up to two per cycle, while `C` is multiplied by the same power of x modulo p.
- The degree test uses a single magnitude comparison rather than a bit scan.
- Fix-up removes up to eight powers of x per cycle.

The controller has five states:
- `S_IDLE` waits for `start`. It goes to `S_FINISH` on a zero operand and to `S_STRIP` otherwise.
- `S_STRIP` shifts while `F` is even. When `F` is odd and equal to 1, it goes to `S_FIX`, or to `S_FINISH` if `k` = 0. When `F` is odd and not 1, it goes to `S_ELIM`.
- `S_ELIM` swaps `G`/`C` with `F`/`B` when deg F < deg G, then adds `G` into `F` and `C` into `B`. It always returns to `S_STRIP`.
- `S_FIX` divides `B` by x^min(k,8) each cycle and goes to `S_FINISH` when `k` reaches 0.
- `S_FINISH` raises `done` and returns to `S_IDLE`.

Top module: `gfinv_top`

## Requirements
- R1: After reset, `done` = 0, `err` = 0 and `result` = 0.
- R2: For any nonzero `operand` accepted by `start`, the `result` present while `done` is high satisfies operand * result = 1 in GF(2)[x] modulo x^89 + x^38 + 1. The result has degree below 89, where bit i holds the coefficient of x^i.
- R3: A zero `operand` accepted by `start` raises `done` and `err` during the cycle right after the accepting clock edge, with `result` = 0.
- R4: `done` is high for exactly one cycle per accepted start.
- R5: A `start` pulse while a computation is in progress is ignored. The running computation completes with the inverse of the operand it accepted.
- R6: After `done`, `result` and `err` keep their values until the next accepted start, whatever `operand` does.
- R7: A nonzero operand accepted after a zero one clears `err`.
- R8: Operand 1 returns 1, with `done` in the second cycle after the accepting edge. Operand x (bit 1 only) returns x^88 + x^37.
- R9: `done` arrives no later than 5*89 cycles after the accepting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request; accepted only in the idle state |
| operand | input | 89 | Element to invert, bit i = coefficient of x^i |
| result | output | 89 | Inverse, valid from `done` until the next accepted start |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Set when the accepted operand was zero |

## Verification
Most results have a data-dependent latency. The bench therefore counts cycles from the accepting edge at every falling edge and reads `result` and `err` in the falling-edge window where `done` is first seen. Two cases have fixed latency. A zero operand must show `done` at the first falling edge after acceptance, and operand 1 at the second; both counts are compared exactly. For every other operand, the count must stay within 5*89. The bench also checks that `done` is low at the next falling edge, and that `result` has not moved several cycles later.

// File: rtl/gfinv_pkg.sv
package gfinv_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_STRIP,
        S_ELIM,
        S_FIX,
        S_FINISH
    } inv_state_e;

endpackage

// File: rtl/gfinv_degcmp.sv
// Degree comparison without locating either leading one: the bits of g
// that f lacks exceed f exactly when g's top bit lies above f's.
module gfinv_degcmp #(
    parameter int W = 90
) (
    input  logic [W-1:0] f,
    input  logic [W-1:0] g,
    output logic         f_lower
);
    logic [W-1:0] g_only;

    always_comb begin
        g_only  = g & ~f;
        f_lower = (g_only > f);
    end
endmodule

// File: rtl/gfinv_strip.sv
// Removes up to STRIP_BITS trailing zeros of f; multiplies c by the
// same power of x, reduced modulo the trinomial.
module gfinv_strip #(
    parameter int M          = 89,
    parameter int TAP        = 38,
    parameter int STRIP_BITS = 2,
    parameter int SW         = $clog2(STRIP_BITS + 1)
) (
    input  logic [M:0]    f,
    input  logic [M-1:0]  c,
    output logic [M:0]    f_out,
    output logic [M-1:0]  c_out,
    output logic [SW-1:0] shamt
);
    localparam logic [M-1:0] RED = (M'(1) << TAP) | M'(1);

    logic [M-1:0] c_st [STRIP_BITS+1];

    assign c_st[0] = c;

    for (genvar j = 1; j <= STRIP_BITS; j++) begin : g_mulx
        assign c_st[j] = {c_st[j-1][M-2:0], 1'b0} ^ (c_st[j-1][M-1] ? RED : '0);
    end

    always_comb begin
        logic stop;
        stop  = 1'b0;
        shamt = '0;
        for (int j = 0; j < STRIP_BITS; j++) begin
            if (!stop && !f[j]) begin
                shamt = shamt + SW'(1);
            end else begin
                stop = 1'b1;
            end
        end
        f_out = f >> shamt;
        c_out = c_st[shamt];
    end
endmodule

// File: rtl/gfinv_fix.sv
// One fix-up step: b * x^-step mod p, step = min(k, R). The low step
// bits t are cancelled by adding t*p, then the value is shifted right.
module gfinv_fix #(
    parameter int M   = 89,
    parameter int TAP = 38,
    parameter int R   = 8,
    parameter int KW  = 9
) (
    input  logic [M-1:0]  b,
    input  logic [KW-1:0] k,
    output logic [M-1:0]  b_out,
    output logic [KW-1:0] step
);
    logic [M-1:0] t;
    logic [M-1:0] sum;

    always_comb begin
        step = (k > KW'(R)) ? KW'(R) : k;
        t    = '0;
        for (int i = 0; i < R; i++) begin
            if (KW'(i) < step) t[i] = b[i];
        end
        sum   = b ^ t ^ (t << TAP);
        b_out = (sum >> step) | (t << (M - int'(step)));
    end
endmodule

// File: rtl/gfinv_top.sv
module gfinv_top #(
    parameter int M          = 89,
    parameter int TAP        = 38,
    parameter int STRIP_BITS = 2,
    parameter int FIX_BITS   = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] operand,
    output logic [M-1:0] result,
    output logic         done,
    output logic         err
);
    import gfinv_pkg::*;

    localparam int KW = $clog2(2 * M + 1) + 1;
    localparam int SW = $clog2(STRIP_BITS + 1);
    localparam logic [M:0] POLY = ((M + 1)'(1) << M) | ((M + 1)'(1) << TAP) | (M + 1)'(1);

    inv_state_e    state_q, state_n;
    logic [M:0]    f_q, g_q;
    logic [M-1:0]  b_q, c_q;
    logic [KW-1:0] k_q;
    logic          err_q;

    logic [M:0]    f_sh;
    logic [M-1:0]  c_sh;
    logic [SW-1:0] shamt;
    logic          f_lower;
    logic [M-1:0]  b_fix;
    logic [KW-1:0] fix_step;
    logic          f_is_one;
    logic          op_zero;

    gfinv_strip #(.M(M), .TAP(TAP), .STRIP_BITS(STRIP_BITS), .SW(SW)) u_strip (
        .f     (f_q),
        .c     (c_q),
        .f_out (f_sh),
        .c_out (c_sh),
        .shamt (shamt)
    );

    gfinv_degcmp #(.W(M + 1)) u_degcmp (
        .f       (f_q),
        .g       (g_q),
        .f_lower (f_lower)
    );

    gfinv_fix #(.M(M), .TAP(TAP), .R(FIX_BITS), .KW(KW)) u_fix (
        .b     (b_q),
        .k     (k_q),
        .b_out (b_fix),
        .step  (fix_step)
    );

    assign f_is_one = (f_q == (M + 1)'(1));
    assign op_zero  = (operand == '0);

    // next state
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start) state_n = op_zero ? S_FINISH : S_STRIP;
            end
            S_STRIP: begin
                if (f_q[0]) begin
                    if (f_is_one) state_n = (k_q == '0) ? S_FINISH : S_FIX;
                    else          state_n = S_ELIM;
                end
            end
            S_ELIM:   state_n = S_STRIP;
            S_FIX: begin
                if (k_q <= KW'(FIX_BITS)) state_n = S_FINISH;
            end
            S_FINISH: state_n = S_IDLE;
            default:  state_n = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_n;
    end

    // working registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q   <= '0;
            g_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            k_q   <= '0;
            err_q <= 1'b0;
        end else begin
            unique case (state_q)
                S_IDLE: begin
                    if (start) begin
                        err_q <= op_zero;
                        f_q   <= {1'b0, operand};
                        g_q   <= POLY;
                        b_q   <= op_zero ? '0 : M'(1);
                        c_q   <= '0;
                        k_q   <= '0;
                    end
                end
                S_STRIP: begin
                    if (!f_q[0]) begin
                        f_q <= f_sh;
                        c_q <= c_sh;
                        k_q <= k_q + KW'(shamt);
                    end
                end
                S_ELIM: begin
                    f_q <= f_q ^ g_q;
                    b_q <= b_q ^ c_q;
                    if (f_lower) begin
                        g_q <= f_q;
                        c_q <= b_q;
                    end
                end
                S_FIX: begin
                    b_q <= b_fix;
                    k_q <= k_q - fix_step;
                end
                S_FINISH: ;
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        done   = (state_q == S_FINISH);
        err    = err_q;
        result = b_q;
    end
endmodule

// File: rtl/gfinv_chk.sv
module gfinv_chk #(
    parameter int M  = 89,
    parameter int KW = 9
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic [M-1:0]           operand,
    input logic [M-1:0]           result,
    input logic                   done,
    input logic                   err,
    input gfinv_pkg::inv_state_e  state,
    input logic [KW-1:0]          k
);
    import gfinv_pkg::*;

    // R4
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && start && operand == '0) |=> (done && err && result == '0));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE && !start) |=> ($stable(result) && $stable(err)));

    // R2
    nonzero_res_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (result != '0));

    // R9
    k_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        k <= KW'(2 * M));
endmodule

bind gfinv_top gfinv_chk #(.M(M), .KW(KW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .operand (operand),
    .result  (result),
    .done    (done),
    .err     (err),
    .state   (state_q),
    .k       (k_q)
);

// File: tb/gfinv_top_bench.sv
`timescale 1ns/1ps
module gfinv_top_bench;
    localparam int M   = 89;
    localparam int TAP = 38;
    localparam int LIM = 5 * M;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] operand = '0;
    logic [M-1:0] result;
    logic         done;
    logic         err;

    int n_checks = 0;
    int n_fail   = 0;

    always #5 clk = ~clk;

    gfinv_top u_gfinv_top (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .operand (operand),
        .result  (result),
        .done    (done),
        .err     (err)
    );

    function automatic logic [M-1:0] gf_mul(input logic [M-1:0] a, input logic [M-1:0] b);
        logic [M-1:0] acc = '0;
        logic [M-1:0] s = a;
        for (int i = 0; i < M; i++) begin
            if (b[i]) acc ^= s;
            s = {s[M-2:0], 1'b0} ^ (s[M-1] ? ((M'(1) << TAP) | M'(1)) : '0);
        end
        return acc;
    endfunction

    task automatic check(input bit ok, input string tag, input logic [M-1:0] act, input logic [M-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Pulse start with operand a; if clash>0, pulse start again with
    // operand b at that cycle count while busy. Returns latency in cycles.
    task automatic run_op(input logic [M-1:0] a, input int clash, input logic [M-1:0] b,
                          output logic [M-1:0] res, output logic e, output int lat);
        @(negedge clk);
        operand = a;
        start   = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat   = 1;
        while (!done && lat < LIM + 2) begin
            if (clash > 0 && lat == clash) begin
                operand = b;
                start   = 1'b1;
            end
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        res = result;
        e   = err;
        check(done === 1'b1, "R9 done seen", M'(lat), M'(LIM));
        @(negedge clk);
        check(done === 1'b0, "R4 done one cycle", M'(done), '0);
    endtask

    task automatic inv_check(input logic [M-1:0] a, input string tag);
        logic [M-1:0] r;
        logic e;
        int lat;
        run_op(a, 0, '0, r, e, lat);
        check(gf_mul(a, r) == M'(1) && e == 1'b0, tag, gf_mul(a, r), M'(1));
        check(lat <= LIM, "R9 latency bound", M'(lat), M'(LIM));
    endtask

    initial begin
        #(200000 * 10);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [M-1:0] r;
        logic [M-1:0] r2;
        logic         e;
        int           lat;
        int           seed_init;

        seed_init = $urandom(32'h5EED_0489);
        #2;
        // R1 reset state
        check(done === 1'b0 && err === 1'b0, "R1 reset flags", {87'b0, done, err}, '0);
        check(result === '0, "R1 reset result", result, '0);
        #20;
        rst_n = 1'b1;

        // R8 operand 1: done on the second cycle
        run_op(M'(1), 0, '0, r, e, lat);
        check(r == M'(1), "R8 one inverse", r, M'(1));
        check(lat == 2, "R8 one latency", M'(lat), M'(2));

        // R8 operand x
        run_op(M'(2), 0, '0, r, e, lat);
        check(r == ((M'(1) << 88) | (M'(1) << 37)), "R8 x inverse", r, (M'(1) << 88) | (M'(1) << 37));

        // R3 zero operand
        run_op('0, 0, '0, r, e, lat);
        check(e == 1'b1, "R3 err on zero", M'(e), M'(1));
        check(r == '0, "R3 zero result", r, '0);
        check(lat == 1, "R3 zero latency", M'(lat), M'(1));

        // R6 hold after done while operand moves
        operand = {M{1'b1}};
        repeat (5) @(negedge clk);
        check(err == 1'b1 && result == '0, "R6 hold after zero", result, '0);

        // R7 nonzero clears err
        inv_check(M'(3), "R7 R2 err cleared, x+1");

        // R2 directed corners
        inv_check({M{1'b1}}, "R2 all ones");
        inv_check(M'(1) << 88, "R2 x^88");
        inv_check((M'(1) << TAP) | M'(1), "R2 x^38+1");
        inv_check(M'(1) << 8, "R2 x^8");
        inv_check(M'(1) << 9, "R2 x^9");

        // R5 start while busy is ignored
        begin
            logic [M-1:0] a5 = 89'h0ABC_DEF0_1234_5678_9ABC;
            run_op(a5, 3, M'(1), r, e, lat);
            check(gf_mul(a5, r) == M'(1), "R5 busy start ignored", gf_mul(a5, r), M'(1));
            operand = '0;
            repeat (4) @(negedge clk);
            check(result == r && err == 1'b0, "R6 hold after nonzero", result, r);
        end

        // R2 random operands
        for (int n = 0; n < 30; n++) begin
            logic [M-1:0] a;
            a = M'({$urandom(), $urandom(), $urandom()});
            if (a == '0) a = M'(5);
            inv_check(a, "R2 random inverse");
        end

        // R2 inverse of inverse returns the operand
        run_op(89'h1_2345_6789_ABCD_EF01_2345, 0, '0, r, e, lat);
        run_op(r, 0, '0, r2, e, lat);
        check(r2 == 89'h1_2345_6789_ABCD_EF01_2345, "R2 double inverse", r2, 89'h1_2345_6789_ABCD_EF01_2345);

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule